// File: doc/BRIEF.md
# Reset and Wake Sequencer

This block produces the chip-wide reset. Two sources can request it: an external active-low reset pin and a one-cycle request from the watchdog. The pin first passes through a synchronizer and a digital glitch filter. The watchdog request is stretched so that even a single-cycle pulse is handled. While any request is active, the internal reset is held asserted and the settle counter is kept at zero.

Reset is released only when all four conditions hold at once. The pin must be released, the oscillator-good input must be high, the settle counter must have seen `HOLD_CYCLES` clocks with the oscillator running, and the flash controller must report that its initialisation is done. After release, the processor starts from its reset vector with every register at its reset value.

The same settle counter paces the return from power-down, because the oscillator is stopped while the chip sleeps. A wake event in the sleep state restarts the count. When the count completes, the block gives a single-cycle wake-complete pulse, and the internal reset is not asserted at any point in that sequence.

Top module: `rstwake_ctrl`

## Requirements
- R1: `sys_rst_n_o` is low while `por_n_i` is low and right after it rises. It goes low `SYNC_STAGES+FILTER_LEN+1` clock edges after the pin is driven low and held low, where it was high before.
- R2: A change on `pin_rst_n_i` takes effect only after the synchronized pin has held its new level for `FILTER_LEN` consecutive clock samples. A low pulse shorter than that leaves `sys_rst_n_o` high.
- R3: A one-cycle high pulse on `wdt_rst_i` drives `sys_rst_n_o` low on the second edge after the pulse is sampled. With the oscillator and flash ready, reset is released `WDT_STRETCH+HOLD_CYCLES+2` edges after that sample.
- R4: Reset is released only on an edge where the pin is released, `osc_ok_i` is high, the settle count is complete and `flash_done_i` is high. With all of these true, release comes `SYNC_STAGES+FILTER_LEN+HOLD_CYCLES+1` edges after the pin is released. If only `flash_done_i` is missing, release comes one edge after it rises.
- R5: The settle count advances only on edges where `osc_ok_i` is high. Edges with `osc_ok_i` low delay the release by the same number of edges, and reset is never released on such an edge.
- R6: A new reset request that arrives while the count is running restarts the count from zero. Release is then timed from the latest request.
- R7: A high sample of `pdown_i` while the chip runs puts the block into sleep, and `sys_rst_n_o` stays high. A `wake_i` sample in sleep restarts the count, and `wake_done_o` is high for exactly one cycle, `HOLD_CYCLES+2` edges after that sample.
- R8: `wake_i` has no effect while the chip is running: `wake_done_o` stays low and `sys_rst_n_o` stays high.
- R9: A reset request from either source during sleep or during the wake count takes precedence. It asserts the internal reset, no wake-complete pulse follows, and release then follows R3 or R4.
- R10: `wake_done_o` is never high while `sys_rst_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_n_i | input | 1 | Asynchronous power-on reset for the block itself, active low |
| pin_rst_n_i | input | 1 | Raw external reset pin, active low, asynchronous |
| wdt_rst_i | input | 1 | Watchdog reset request, may last a single cycle |
| osc_ok_i | input | 1 | Oscillator running and stable |
| flash_done_i | input | 1 | Flash controller initialisation complete |
| pdown_i | input | 1 | Request to enter power-down |
| wake_i | input | 1 | Wake event from power-down |
| sys_rst_n_o | output | 1 | Internal chip reset, active low |
| wake_done_o | output | 1 | One-cycle pulse when a power-down wake finishes |

## Verification
Two pairs of functions can coincide. A watchdog or pin reset can arrive during the wake count, and a second reset request can land while an earlier settle count is still running. The bench provokes the first case by pulsing the watchdog a few cycles after a wake event. It judges the result by checking that reset asserts, that no wake-complete pulse ever appears, and that release comes on the edge predicted from the latest request. Restarts are provoked at random offsets inside the count, and the release edge is predicted from the second pulse alone.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;
   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_RUN   = 2'd1,
      ST_SLEEP = 2'd2,
      ST_WAKE  = 2'd3
   } rw_state_e;
endpackage

// File: rtl/rw_pin_filter.sv
module rw_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILTER_LEN  = 4
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic raw_i,
   output logic filt_o
);
   localparam int FW = $clog2(FILTER_LEN + 1);

   logic smp;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign smp = raw_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) sr_q <= '0;
            else          sr_q <= {sr_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], raw_i} & {SYNC_STAGES{1'b1}};
         end
         assign smp = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [FW-1:0] run_q;
   logic          filt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         run_q  <= '0;
         filt_q <= 1'b0;
      end else if (smp == filt_q) begin
         run_q <= '0;
      end else if (run_q == FW'(FILTER_LEN - 1)) begin
         run_q  <= '0;
         filt_q <= smp;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign filt_o = filt_q;
endmodule

// File: rtl/rw_pulse_stretch.sv
module rw_pulse_stretch #(
   parameter int STRETCH = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic pulse_i,
   output logic long_o
);
   localparam int SW = $clog2(STRETCH + 1);

   logic [SW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)           left_q <= '0;
      else if (pulse_i)       left_q <= SW'(STRETCH);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign long_o = (left_q != '0);
endmodule

// File: rtl/rw_settle_count.sv
module rw_settle_count #(
   parameter int LIMIT = 4096
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic clr_i,
   input  logic en_i,
   output logic done_o
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;
   logic          full;

   assign full = (cnt_q == CW'(LIMIT));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)          cnt_q <= '0;
      else if (clr_i)        cnt_q <= '0;
      else if (en_i && !full) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = full;
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
   import rstwake_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILTER_LEN  = 4,
   parameter int HOLD_CYCLES = 4096,
   parameter int WDT_STRETCH = 2
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic pin_rst_n_i,
   input  logic wdt_rst_i,
   input  logic osc_ok_i,
   input  logic flash_done_i,
   input  logic pdown_i,
   input  logic wake_i,
   output logic sys_rst_n_o,
   output logic wake_done_o
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (FILTER_LEN < 2) begin : g_bad_filt
         $error("FILTER_LEN must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (WDT_STRETCH < 1) begin : g_bad_str
         $error("WDT_STRETCH must be at least 1");
      end
   endgenerate

   logic      pin_ok;
   logic      wdt_long;
   logic      req;
   logic      cnt_clr;
   logic      cnt_done;
   rw_state_e st_q, st_d;
   logic      wdone_q;

   rw_pin_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILTER_LEN  (FILTER_LEN)
   ) u_pin (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .raw_i   (pin_rst_n_i),
      .filt_o  (pin_ok)
   );

   rw_pulse_stretch #(
      .STRETCH (WDT_STRETCH)
   ) u_wdt (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .pulse_i (wdt_rst_i),
      .long_o  (wdt_long)
   );

   assign req     = !pin_ok || wdt_long;
   assign cnt_clr = req || (st_q == ST_SLEEP);

   rw_settle_count #(
      .LIMIT (HOLD_CYCLES)
   ) u_cnt (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .clr_i   (cnt_clr),
      .en_i    (osc_ok_i),
      .done_o  (cnt_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_HOLD:  if (!req && osc_ok_i && cnt_done && flash_done_i) st_d = ST_RUN;
         ST_RUN:   if (req) st_d = ST_HOLD;
                   else if (pdown_i) st_d = ST_SLEEP;
         ST_SLEEP: if (req) st_d = ST_HOLD;
                   else if (wake_i) st_d = ST_WAKE;
         ST_WAKE:  if (req) st_d = ST_HOLD;
                   else if (cnt_done && osc_ok_i) st_d = ST_RUN;
         default:  st_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         st_q    <= ST_HOLD;
         wdone_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         wdone_q <= (st_q == ST_WAKE) && (st_d == ST_RUN);
      end
   end

   assign sys_rst_n_o = (st_q != ST_HOLD);
   assign wake_done_o = wdone_q;
endmodule

// File: rtl/rstwake_ctrl_chk.sv
module rstwake_ctrl_chk (
   input logic clk_i,
   input logic por_n_i,
   input logic pin_rst_n_i,
   input logic wdt_rst_i,
   input logic osc_ok_i,
   input logic flash_done_i,
   input logic sys_rst_n_o,
   input logic wake_done_o
);
   AST_WDT_ASSERTS: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wdt_rst_i |=> ##1 !sys_rst_n_o); // R3

   AST_RELEASE_FLASH: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(sys_rst_n_o) |-> $past(flash_done_i)); // R4

   AST_RELEASE_PIN: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(sys_rst_n_o) |-> $past(pin_rst_n_i)); // R4

   AST_NO_RELEASE_OSC_LOW: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!sys_rst_n_o && !osc_ok_i) |=> !sys_rst_n_o); // R5

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wake_done_o |=> !wake_done_o); // R7

   AST_WAKE_NOT_IN_RESET: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wake_done_o |-> sys_rst_n_o); // R10
endmodule

bind rstwake_ctrl rstwake_ctrl_chk u_chk (
   .clk_i        (clk_i),
   .por_n_i      (por_n_i),
   .pin_rst_n_i  (pin_rst_n_i),
   .wdt_rst_i    (wdt_rst_i),
   .osc_ok_i     (osc_ok_i),
   .flash_done_i (flash_done_i),
   .sys_rst_n_o  (sys_rst_n_o),
   .wake_done_o  (wake_done_o)
);

// File: tb/rstwake_ctrl_bench.sv
module rstwake_ctrl_bench;
   localparam int SY = 2;
   localparam int FL = 4;
   localparam int HC = 16;
   localparam int ST = 2;

   logic clk = 1'b0;
   logic por_n, pin_n, wdt, osc, flash, pdown, wake;
   logic sys_rst_n, wake_done;
   int   n_cmp = 0;
   int   n_bad = 0;

   always #2 clk = ~clk;

   rstwake_ctrl #(
      .SYNC_STAGES (SY),
      .FILTER_LEN  (FL),
      .HOLD_CYCLES (HC),
      .WDT_STRETCH (ST)
   ) u_rstwake_ctrl (
      .clk_i        (clk),
      .por_n_i      (por_n),
      .pin_rst_n_i  (pin_n),
      .wdt_rst_i    (wdt),
      .osc_ok_i     (osc),
      .flash_done_i (flash),
      .pdown_i      (pdown),
      .wake_i       (wake),
      .sys_rst_n_o  (sys_rst_n),
      .wake_done_o  (wake_done)
   );

   function automatic int pin_release_edge();
      return SY + FL + HC + 1;
   endfunction

   function automatic int wdt_release_edge();
      return ST + HC + 2;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wdt_pulse();
      wdt = 1'b1;
      tick(1);
      wdt = 1'b0;
   endtask

   task automatic recover();
      pin_n = 1'b1; osc = 1'b1; flash = 1'b1; pdown = 1'b0; wake = 1'b0;
      for (int i = 0; i < 200 && !sys_rst_n; i++) tick(1);
      tick(2);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      logic seen;
      void'($urandom(32'h5EED));
      por_n = 1'b0; pin_n = 1'b0; wdt = 1'b0; osc = 1'b1;
      flash = 1'b1; pdown = 1'b0; wake = 1'b0;
      tick(3);
      chk(sys_rst_n, 1'b0, "R1 reset during power-on");
      por_n = 1'b1; pin_n = 1'b1;
      tick(pin_release_edge() - 1);
      chk(sys_rst_n, 1'b0, "R4 held until last edge");
      tick(1);
      chk(sys_rst_n, 1'b1, "R4 release edge after power-on");

      // pin assertion and release timing
      pin_n = 1'b0;
      tick(SY + FL);
      chk(sys_rst_n, 1'b1, "R1 pin not yet accepted");
      tick(1);
      chk(sys_rst_n, 1'b0, "R1 pin reset asserted");
      pin_n = 1'b1;
      tick(pin_release_edge() - 1);
      chk(sys_rst_n, 1'b0, "R4 pin release early");
      tick(1);
      chk(sys_rst_n, 1'b1, "R4 pin release edge");

      // random pin pulse lengths through the glitch filter
      for (int it = 0; it < 16; it++) begin
         int len;
         len = $urandom_range(1, 7);
         pin_n = 1'b0;
         tick(len);
         pin_n = 1'b1;
         tick(8 - len);
         chk(sys_rst_n, (len < FL) ? 1'b1 : 1'b0, "R2 glitch filter length");
         recover();
      end

      // single-cycle watchdog request
      wdt_pulse();
      tick(1);
      chk(sys_rst_n, 1'b0, "R3 watchdog asserts reset");
      tick(wdt_release_edge() - 3);
      chk(sys_rst_n, 1'b0, "R3 watchdog hold");
      tick(1);
      chk(sys_rst_n, 1'b1, "R3 watchdog release edge");

      // restart during the count
      for (int it = 0; it < 3; it++) begin
         int p;
         p = $urandom_range(3, 15);
         wdt_pulse();
         tick(p - 1);
         wdt_pulse();
         tick(wdt_release_edge() - 2);
         chk(sys_rst_n, 1'b0, "R6 restart hold");
         tick(1);
         chk(sys_rst_n, 1'b1, "R6 restart release edge");
         recover();
      end

      // flash not ready
      flash = 1'b0;
      wdt_pulse();
      tick(40);
      chk(sys_rst_n, 1'b0, "R4 waits for flash");
      flash = 1'b1;
      tick(1);
      chk(sys_rst_n, 1'b1, "R4 release after flash");

      // oscillator stopped then started
      osc = 1'b0;
      wdt_pulse();
      tick(40);
      chk(sys_rst_n, 1'b0, "R5 no count without oscillator");
      osc = 1'b1;
      tick(HC);
      chk(sys_rst_n, 1'b0, "R5 hold while counting");
      tick(1);
      chk(sys_rst_n, 1'b1, "R5 release after oscillator count");

      // random oscillator gaps
      for (int it = 0; it < 4; it++) begin
         int   ones;
         logic done, rel, bad;
         ones = 0; done = 1'b0; rel = 1'b0; bad = 1'b0;
         wdt_pulse();
         tick(2);
         for (int k = 0; k < 300 && !rel; k++) begin
            logic exp;
            osc = ($urandom_range(0, 3) != 0);
            tick(1);
            exp = done && osc;
            if (sys_rst_n !== exp) bad = 1'b1;
            if (exp) rel = 1'b1;
            if (!done && osc) ones++;
            if (ones == HC) done = 1'b1;
         end
         chk(bad, 1'b0, "R5 release with oscillator gaps");
         recover();
      end

      // power-down and wake
      pdown = 1'b1;
      tick(1);
      pdown = 1'b0; osc = 1'b0;
      tick(10);
      chk(sys_rst_n, 1'b1, "R7 reset stays released in sleep");
      wake = 1'b1; osc = 1'b1;
      tick(1);
      wake = 1'b0;
      tick(HC);
      chk(wake_done, 1'b0, "R7 wake not yet done");
      tick(1);
      chk(wake_done, 1'b1, "R7 wake done pulse");
      tick(1);
      chk(wake_done, 1'b0, "R7 wake pulse one cycle");
      chk(sys_rst_n, 1'b1, "R7 running after wake");

      // wake while running
      wake = 1'b1;
      tick(1);
      wake = 1'b0;
      seen = 1'b0;
      for (int k = 0; k < 25; k++) begin
         tick(1);
         if (wake_done || !sys_rst_n) seen = 1'b1;
      end
      chk(seen, 1'b0, "R8 wake ignored when running");

      // watchdog during wake count
      pdown = 1'b1;
      tick(1);
      pdown = 1'b0;
      tick(3);
      wake = 1'b1;
      tick(1);
      wake = 1'b0;
      tick(4);
      seen = 1'b0;
      wdt_pulse();
      tick(1);
      chk(sys_rst_n, 1'b0, "R9 watchdog during wake asserts reset");
      for (int k = 0; k < wdt_release_edge() - 3; k++) begin
         tick(1);
         if (wake_done) seen = 1'b1;
      end
      chk(sys_rst_n, 1'b0, "R9 hold after wake interrupted");
      tick(1);
      if (wake_done) seen = 1'b1;
      chk(sys_rst_n, 1'b1, "R9 release after wake interrupted");
      tick(5);
      if (wake_done) seen = 1'b1;
      chk(seen, 1'b0, "R9 no wake pulse after interruption");

      // pin reset during sleep
      pdown = 1'b1;
      tick(1);
      pdown = 1'b0;
      pin_n = 1'b0;
      tick(10);
      chk(sys_rst_n, 1'b0, "R9 pin reset during sleep");
      pin_n = 1'b1;
      tick(pin_release_edge() - 1);
      chk(sys_rst_n, 1'b0, "R9 pin release early from sleep");
      tick(1);
      chk(sys_rst_n, 1'b1, "R9 pin release from sleep");

      summary();
      $finish;
   end
endmodule